// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a single-clock synchronous static RAM whose words are four 9-bit lanes. Each lane holds eight data bits and one parity bit. Every input is captured on the rising clock edge. A read address taken at one edge has its data in the output register after the following edge. A write is captured at one edge and committed to the array at the next edge, with no further handshake.

Accesses come in bursts of up to four words. A burst starts when either of two address strobes is asserted. A processor strobe always starts a read. A controller strobe starts a read or a write, chosen by the write controls sampled on that same edge. After the start, a separate advance input either steps a 2-bit burst counter or holds it. The counter is combined with the two low address bits, either by XOR (interleaved order) or by addition modulo 4 (linear order). Three chip selects gate burst starts. An asynchronous output enable gates the data drive flag. A sleep input parks the block and makes it wait a fixed wake-up time before it accepts commands again.

Control is split into a power state machine and a command decoder. The power machine has the states RUN, SLEEP, WAKE_A, WAKE_B and WAKE_C, with these transitions:
- RUN goes to SLEEP when sleep is seen high.
- SLEEP goes to WAKE_A when sleep is seen low.
- WAKE_A goes to WAKE_B, then WAKE_C, then RUN, one edge each.
- Any WAKE state returns to SLEEP if sleep is seen high.

The burst tracker has two states, OFF and ON. A start moves it to ON, and a deselect moves it to OFF. Each edge the decoder classifies the inputs as one of HOLD, DESELECT, START_CPU, START_CTL, NEXT or STAY.

Top module: `pipe_burst_sram`

## Requirements
- R1: Lane i is the field `din[9*i+8:9*i]`, and bit 9*i+8 is that lane's parity bit. A write changes lane i only when `wr_all_n` is 0, or when `wr_en_n` is 0 and `lane_wr_n[i]` is 0. A low `wr_all_n` writes all four lanes whatever the other write inputs are.
- R2: When `wr_all_n` is 1, the access is a read if `wr_en_n` is 1, or if `lane_wr_n` is 4'b1111. A read leaves the memory unchanged.
- R3: Chips are enabled when `sel_n`=0, `sel_hi`=1 and `sel2_n`=0. With chips enabled, `strobe_cpu_n`=0 starts a burst at `addr` as a read, whatever the write inputs are. Write controls presented on the next edge, with `adv_n`=1, write that same address.
- R4: With chips enabled, `strobe_cpu_n`=1 and `strobe_ctl_n`=0, a burst starts at `addr`. It is a write or a read according to the write controls sampled on that edge.
- R5: A read accepted at edge k sets `dout_drive` and presents the word on `dout` after edge k+1. A write or a non-access at edge k leaves `dout_drive` low after edge k+1.
- R6: With `linear_mode`=0, burst beat c (c = 0..3) uses address bits [1:0] = base[1:0] XOR c. The upper bits stay those of the base.
- R7: With `linear_mode`=1, burst beat c uses address bits [1:0] = (base[1:0] + c) mod 4. The upper bits stay those of the base.
- R8: With both strobes at 1 during a burst, `adv_n`=0 steps to the next beat, and `adv_n`=1 accesses the current beat again.
- R9: A strobe with `sel_n`=0 but `sel_hi`=0 or `sel2_n`=1 deselects: there is no access and the burst ends. `sel_n`=1 together with `strobe_ctl_n`=0 also deselects. After a deselect, cycles without a strobe make no access.
- R10: `sel_n`=1 together with `strobe_cpu_n`=0 and `strobe_ctl_n`=1 does not start a burst; the running burst continues as in R8.
- R11: `oe_n`=1 forces `dout_drive` low immediately, without a clock edge, and leaves the output register unchanged.
- R12: Edges that see `sleep`=1 make no access, and `dout_drive` stays low. After the first edge that sees `sleep` low, the next three edges are also ignored, and the fourth is accepted. Memory contents are preserved throughout.
- R13: After reset, `dout_drive` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | AW | Word address for burst starts |
| sel_n | input | 1 | Primary chip select, active low |
| sel_hi | input | 1 | Secondary chip select, active high |
| sel2_n | input | 1 | Tertiary chip select, active low |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, forces read start |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_en_n | input | 1 | Per-lane write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| linear_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Output register contents |
| dout_drive | output | 1 | High when dout would drive the bus |

## Verification
The bench checks that a processor-strobe start with the write controls low still reads. A design that honoured those controls would corrupt the word and return the new value. It walks both burst orders and mixes advance and hold cycles. A sequencer with the wrong order, or one that steps on hold, writes to or reads from the wrong neighbour, and the shadow comparison then fails. It also checks wake-up timing: write attempts on every ignored edge are followed by a read on the first accepted edge, so a wake-up that is one cycle short returns corrupted data. The remaining checks cover the two deselect forms and the ignored processor strobe while `sel_n` is high. A decoder that got these wrong would either drive data after a deselect or restart the burst at a new address.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE
    } op_e;

    typedef enum logic [2:0] {
        PWR_RUN,
        PWR_SLEEP,
        PWR_WAKE_A,
        PWR_WAKE_B,
        PWR_WAKE_C
    } pwr_e;

    typedef enum logic {
        BST_OFF,
        BST_ON
    } bst_e;

    typedef enum logic [2:0] {
        CMD_HOLD,
        CMD_DESEL,
        CMD_START_CPU,
        CMD_START_CTL,
        CMD_NEXT,
        CMD_STAY
    } cmd_e;

    // Low two address bits for a burst beat.
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] beat,
                                             input logic       linear);
        return linear ? 2'(base + beat) : (base ^ beat);
    endfunction

endpackage

// File: rtl/sram_power_fsm.sv
module sram_power_fsm
    import sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output pwr_e state_q,
    output logic awake
);

    pwr_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWR_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN:    state_d = sleep ? PWR_SLEEP : PWR_RUN;
            PWR_SLEEP:  state_d = sleep ? PWR_SLEEP : PWR_WAKE_A;
            PWR_WAKE_A: state_d = sleep ? PWR_SLEEP : PWR_WAKE_B;
            PWR_WAKE_B: state_d = sleep ? PWR_SLEEP : PWR_WAKE_C;
            PWR_WAKE_C: state_d = sleep ? PWR_SLEEP : PWR_RUN;
            default:    state_d = PWR_SLEEP;
        endcase
    end

    // An edge accepts commands only in RUN with sleep low.
    always_comb begin
        awake = (state_q == PWR_RUN) && !sleep;
    end

endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
    import sram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             awake,
    input  logic [AW-1:0]    addr,
    input  logic             sel_n,
    input  logic             sel_hi,
    input  logic             sel2_n,
    input  logic             strobe_cpu_n,
    input  logic             strobe_ctl_n,
    input  logic             adv_n,
    input  logic             wr_all_n,
    input  logic             wr_en_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             linear_mode,
    output op_e              op_q,
    output logic [AW-1:0]    addr_q,
    output logic [LANES-1:0] lanes_q,
    output bst_e             bst_q,
    output logic [1:0]       cnt_q
);

    localparam int HI_W = AW - 2;

    cmd_e             cmd;
    logic [LANES-1:0] wr_lanes;
    logic             is_wr;
    logic             chips_ok;
    logic             any_strobe;
    logic [AW-1:0]    base_q;
    logic [AW-1:0]    base_d;
    logic [1:0]       cnt_d;
    bst_e             bst_d;
    op_e              op_d;
    logic [AW-1:0]    addr_d;
    logic [LANES-1:0] lanes_d;
    logic [HI_W-1:0]  base_hi;

    always_comb begin
        if (!wr_all_n) begin
            wr_lanes = '1;
        end else if (!wr_en_n) begin
            wr_lanes = ~lane_wr_n;
        end else begin
            wr_lanes = '0;
        end
        is_wr      = |wr_lanes;
        chips_ok   = !sel_n && sel_hi && !sel2_n;
        any_strobe = !strobe_cpu_n || !strobe_ctl_n;
    end

    // Classify the edge.
    always_comb begin
        if (!awake) begin
            cmd = CMD_HOLD;
        end else if (!sel_n && any_strobe) begin
            if (!chips_ok) begin
                cmd = CMD_DESEL;
            end else if (!strobe_cpu_n) begin
                cmd = CMD_START_CPU;
            end else begin
                cmd = CMD_START_CTL;
            end
        end else if (sel_n && !strobe_ctl_n) begin
            cmd = CMD_DESEL;
        end else if (bst_q == BST_ON) begin
            cmd = adv_n ? CMD_STAY : CMD_NEXT;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    always_comb begin
        base_hi = base_q[AW-1:2];
        bst_d   = bst_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        op_d    = OP_NONE;
        addr_d  = addr_q;
        lanes_d = '0;
        unique case (cmd)
            CMD_HOLD: begin
                op_d = OP_NONE;
            end
            CMD_DESEL: begin
                bst_d = BST_OFF;
            end
            CMD_START_CPU: begin
                bst_d  = BST_ON;
                base_d = addr;
                cnt_d  = 2'd0;
                op_d   = OP_READ;
                addr_d = addr;
            end
            CMD_START_CTL: begin
                bst_d   = BST_ON;
                base_d  = addr;
                cnt_d   = 2'd0;
                op_d    = is_wr ? OP_WRITE : OP_READ;
                addr_d  = addr;
                lanes_d = wr_lanes;
            end
            CMD_NEXT: begin
                cnt_d   = 2'(cnt_q + 2'd1);
                op_d    = is_wr ? OP_WRITE : OP_READ;
                addr_d  = {base_hi, burst_low(base_q[1:0], cnt_d, linear_mode)};
                lanes_d = wr_lanes;
            end
            CMD_STAY: begin
                op_d    = is_wr ? OP_WRITE : OP_READ;
                addr_d  = {base_hi, burst_low(base_q[1:0], cnt_q, linear_mode)};
                lanes_d = wr_lanes;
            end
            default: begin
                op_d = OP_NONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bst_q   <= BST_OFF;
            base_q  <= '0;
            cnt_q   <= 2'd0;
            op_q    <= OP_NONE;
            addr_q  <= '0;
            lanes_q <= '0;
        end else begin
            bst_q   <= bst_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
            op_q    <= op_d;
            addr_q  <= addr_d;
            lanes_q <= lanes_d;
        end
    end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap,
    input  logic [LANES*LANE_W-1:0] din,
    input  op_e                     op,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        lanes,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int DEPTH  = 1 << AW;
    localparam int WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] din_q;

    always_ff @(posedge clk) begin
        if (cap) begin
            din_q <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= (op == OP_READ);
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (op == OP_WRITE && lanes[g]) begin
                mem[addr] <= din_q[g*LANE_W +: LANE_W];
            end
            if (op == OP_READ) begin
                rdata[g*LANE_W +: LANE_W] <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
    import sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    sel_n,
    input  logic                    sel_hi,
    input  logic                    sel2_n,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    adv_n,
    input  logic                    wr_all_n,
    input  logic                    wr_en_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    linear_mode,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_drive
);

    pwr_e             pwr_state;
    logic             awake;
    op_e              acc_op;
    logic [AW-1:0]    acc_addr;
    logic [LANES-1:0] acc_lanes;
    bst_e             burst_state;
    logic [1:0]       burst_cnt;
    logic             rvalid;

    sram_power_fsm u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep   (sleep),
        .state_q (pwr_state),
        .awake   (awake)
    );

    sram_burst_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .awake        (awake),
        .addr         (addr),
        .sel_n        (sel_n),
        .sel_hi       (sel_hi),
        .sel2_n       (sel2_n),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .adv_n        (adv_n),
        .wr_all_n     (wr_all_n),
        .wr_en_n      (wr_en_n),
        .lane_wr_n    (lane_wr_n),
        .linear_mode  (linear_mode),
        .op_q         (acc_op),
        .addr_q       (acc_addr),
        .lanes_q      (acc_lanes),
        .bst_q        (burst_state),
        .cnt_q        (burst_cnt)
    );

    sram_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (awake),
        .din    (din),
        .op     (acc_op),
        .addr   (acc_addr),
        .lanes  (acc_lanes),
        .rdata  (dout),
        .rvalid (rvalid)
    );

    always_comb begin
        dout_drive = rvalid && !oe_n && (pwr_state == PWR_RUN);
    end

endmodule

// File: rtl/pipe_burst_sram_checker.sv
module pipe_burst_sram_checker
    import sram_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sel_n,
    input logic       sel_hi,
    input logic       sel2_n,
    input logic       strobe_cpu_n,
    input logic       strobe_ctl_n,
    input logic       adv_n,
    input logic       wr_all_n,
    input logic       oe_n,
    input logic       sleep,
    input logic       dout_drive,
    input pwr_e       pwr_state,
    input logic       awake,
    input op_e        acc_op,
    input bst_e       burst_state,
    input logic [1:0] burst_cnt
);

    assert_cpu_start_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !sel_n && sel_hi && !sel2_n && !strobe_cpu_n) |=> (acc_op == OP_READ));

    assert_ctl_start_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !sel_n && sel_hi && !sel2_n && strobe_cpu_n && !strobe_ctl_n && !wr_all_n)
        |=> (acc_op == OP_WRITE));

    assert_read_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op == OP_READ) |=> (dout_drive || oe_n || pwr_state != PWR_RUN));

    assert_no_read_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op != OP_READ) |=> !dout_drive);

    assert_hold_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && burst_state == BST_ON && strobe_cpu_n && strobe_ctl_n && adv_n)
        |=> $stable(burst_cnt));

    assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && sel_n && !strobe_ctl_n) |=> (acc_op == OP_NONE && burst_state == BST_OFF));

    assert_asleep_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> (acc_op == OP_NONE));

    assert_wake_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_SLEEP && !sleep) |=> (pwr_state == PWR_WAKE_A));

endmodule

bind pipe_burst_sram pipe_burst_sram_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_n        (sel_n),
    .sel_hi       (sel_hi),
    .sel2_n       (sel2_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .adv_n        (adv_n),
    .wr_all_n     (wr_all_n),
    .oe_n         (oe_n),
    .sleep        (sleep),
    .dout_drive   (dout_drive),
    .pwr_state    (pwr_state),
    .awake        (awake),
    .acc_op       (acc_op),
    .burst_state  (burst_state),
    .burst_cnt    (burst_cnt)
);

// File: tb/pipe_burst_sram_test.sv
module pipe_burst_sram_test;

    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;
    localparam int W = 36;
    localparam int NVEC = 8;
    // {addr[5:0], wr_all_n, wr_en_n, lane_wr_n[3:0], data[35:0]}
    localparam logic [47:0] VEC [NVEC] = '{
        {6'd3,  1'b0, 1'b1, 4'b1111, 36'h9_ABCD_EF01},
        {6'd4,  1'b1, 1'b0, 4'b1110, 36'hF_FFFF_FFFF},
        {6'd5,  1'b1, 1'b0, 4'b0111, 36'hA_5A5A_5A5A},
        {6'd6,  1'b1, 1'b0, 4'b1010, 36'h1_2345_6789},
        {6'd7,  1'b1, 1'b0, 4'b1111, 36'h0_0000_0000},
        {6'd8,  1'b1, 1'b1, 4'b0000, 36'h0_0000_0000},
        {6'd10, 1'b0, 1'b0, 4'b1111, 36'hC_3C3C_3C3C},
        {6'd11, 1'b1, 1'b0, 4'b0000, 36'h8_7654_3210}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          sel_n, sel_hi, sel2_n;
    logic          strobe_cpu_n, strobe_ctl_n, adv_n;
    logic          wr_all_n, wr_en_n;
    logic [3:0]    lane_wr_n;
    logic          linear_mode, oe_n, sleep;
    logic [W-1:0]  din, dout;
    logic          dout_drive;

    logic [W-1:0]  shadow [DEPTH];
    int            n_chk = 0;
    int            n_fail = 0;

    always #5 clk = ~clk;

    pipe_burst_sram #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel_hi(sel_hi),
        .sel2_n(sel2_n), .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
        .adv_n(adv_n), .wr_all_n(wr_all_n), .wr_en_n(wr_en_n), .lane_wr_n(lane_wr_n),
        .linear_mode(linear_mode), .oe_n(oe_n), .sleep(sleep), .din(din),
        .dout(dout), .dout_drive(dout_drive)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [3:0] lane_mask(input logic all_n, input logic en_n, input logic [3:0] l_n);
        if (!all_n) return 4'hF;
        if (!en_n) return ~l_n;
        return 4'h0;
    endfunction

    function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                           input logic [3:0] m);
        logic [W-1:0] r = old;
        for (int i = 0; i < 4; i++) if (m[i]) r[9*i +: 9] = nw[9*i +: 9];
        return r;
    endfunction

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base, input int c,
                                                 input logic lin);
        logic [1:0] lo = lin ? 2'(base[1:0] + 2'(c)) : (base[1:0] ^ 2'(c));
        return {base[AW-1:2], lo};
    endfunction

    function automatic logic [W-1:0] pat(input int i);
        return (36'(i) * 36'h0_1357_9BDF) ^ 36'hF_0F0F_0F0F;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_in();
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
        wr_all_n = 1'b1; wr_en_n = 1'b1; lane_wr_n = 4'hF;
    endtask

    task automatic wr_ctl(input logic [AW-1:0] a, input logic all_n, input logic en_n,
                          input logic [3:0] l_n, input logic [W-1:0] d);
        strobe_ctl_n = 1'b0; addr = a; wr_all_n = all_n; wr_en_n = en_n;
        lane_wr_n = l_n; din = d;
        tick();
        idle_in();
        shadow[a] = merge(shadow[a], d, lane_mask(all_n, en_n, l_n));
    endtask

    task automatic rd_cpu(input logic [AW-1:0] a, output logic [W-1:0] d, output logic dr);
        strobe_cpu_n = 1'b0; addr = a;
        tick();
        idle_in();
        tick();
        d = dout; dr = dout_drive;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual run still going, expected completion");
        summary();
    end

    initial begin
        logic [W-1:0] d;
        logic         dr;
        logic [AW-1:0] a;
        logic [3:0]   m;
        rst_n = 1'b0; sel_n = 1'b0; sel_hi = 1'b1; sel2_n = 1'b0;
        oe_n = 1'b0; sleep = 1'b0; linear_mode = 1'b0; addr = '0; din = '0;
        idle_in();
        repeat (3) tick();
        // R13: reset state
        check("R13 reset drive", W'(dout_drive), W'(0));
        rst_n = 1'b1;
        tick();
        check("R13 no burst after reset", W'(dout_drive), W'(0));

        for (int i = 0; i < DEPTH; i++) wr_ctl(AW'(i), 1'b0, 1'b1, 4'hF, pat(i));
        tick();

        // Vector table: lane writes (R1, R2) and controller-strobe kind (R4)
        for (int v = 0; v < NVEC; v++) begin
            a = VEC[v][47:42];
            m = lane_mask(VEC[v][41], VEC[v][40], VEC[v][39:36]);
            wr_ctl(a, VEC[v][41], VEC[v][40], VEC[v][39:36], VEC[v][35:0]);
            tick();
            check("R4 read/write choice", W'(dout_drive), W'(m == 4'h0));
            rd_cpu(a, d, dr);
            check("R5 read drives", W'(dr), W'(1));
            check(m == 4'h0 ? "R2 read leaves word" : "R1 lane write", d, shadow[a]);
        end

        // R6: interleaved burst write at base 22
        linear_mode = 1'b0;
        strobe_ctl_n = 1'b0; addr = 6'd22; wr_all_n = 1'b0; din = 36'h1_1111_0000;
        tick();
        shadow[beat_addr(6'd22, 0, 1'b0)] = 36'h1_1111_0000;
        for (int c = 1; c < 4; c++) begin
            strobe_ctl_n = 1'b1; adv_n = 1'b0; wr_all_n = 1'b0;
            din = 36'h1_1111_0000 + 36'(c);
            tick();
            shadow[beat_addr(6'd22, c, 1'b0)] = 36'h1_1111_0000 + 36'(c);
        end
        idle_in();
        tick();
        for (int c = 0; c < 4; c++) begin
            rd_cpu(beat_addr(6'd22, c, 1'b0), d, dr);
            check("R6 interleaved beat", d, shadow[beat_addr(6'd22, c, 1'b0)]);
        end

        // R7: linear burst read at base 23
        linear_mode = 1'b1;
        strobe_cpu_n = 1'b0; addr = 6'd23;
        tick();
        strobe_cpu_n = 1'b1; adv_n = 1'b0;
        for (int c = 1; c < 4; c++) begin
            tick();
            check("R7 linear beat", dout, shadow[beat_addr(6'd23, c - 1, 1'b1)]);
        end
        idle_in();
        tick();
        check("R7 linear last beat", dout, shadow[beat_addr(6'd23, 3, 1'b1)]);
        linear_mode = 1'b0;

        // R8: hold and advance mix at base 40
        strobe_cpu_n = 1'b0; addr = 6'd40;
        tick();
        strobe_cpu_n = 1'b1; adv_n = 1'b1;
        tick();
        check("R8 start beat", dout, shadow[40]);
        adv_n = 1'b0;
        tick();
        check("R8 held beat", dout, shadow[40]);
        adv_n = 1'b1;
        tick();
        check("R8 advanced beat", dout, shadow[41]);
        tick();
        check("R8 held after advance", dout, shadow[41]);

        // R3: processor strobe ignores write controls, next edge writes
        strobe_cpu_n = 1'b0; addr = 6'd9; wr_all_n = 1'b0; din = 36'hB_0000_0001;
        tick();
        strobe_cpu_n = 1'b1; adv_n = 1'b1; wr_all_n = 1'b0; din = 36'hB_0000_0002;
        tick();
        check("R3 start is read", dout, shadow[9]);
        shadow[9] = 36'hB_0000_0002;
        idle_in();
        tick();
        rd_cpu(6'd9, d, dr);
        check("R3 following write", d, shadow[9]);

        // R9: deselect forms
        strobe_cpu_n = 1'b0; addr = 6'd30;
        tick();
        strobe_cpu_n = 1'b1; sel_hi = 1'b0; strobe_ctl_n = 1'b0;
        tick();
        sel_hi = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b0;
        tick();
        check("R9 deselect no drive", W'(dout_drive), W'(0));
        tick();
        check("R9 no access after deselect", W'(dout_drive), W'(0));
        idle_in();
        sel2_n = 1'b1;
        strobe_ctl_n = 1'b0; addr = 6'd31; wr_all_n = 1'b0; din = 36'hE_EEEE_EEEE;
        tick();
        idle_in(); sel2_n = 1'b0;
        rd_cpu(6'd31, d, dr);
        check("R9 deselected write dropped", d, shadow[31]);
        sel_n = 1'b1;
        strobe_ctl_n = 1'b0; addr = 6'd32; wr_all_n = 1'b0; din = 36'hE_EEEE_EEEE;
        tick();
        idle_in(); sel_n = 1'b0;
        rd_cpu(6'd32, d, dr);
        check("R9 sel_n high deselect", d, shadow[32]);

        // R10: processor strobe with sel_n high continues the burst
        strobe_cpu_n = 1'b0; addr = 6'd44;
        tick();
        sel_n = 1'b1; strobe_cpu_n = 1'b0; addr = 6'd0; adv_n = 1'b0;
        tick();
        check("R10 first beat", dout, shadow[44]);
        sel_n = 1'b0; idle_in();
        tick();
        check("R10 burst continued", dout, shadow[45]);

        // R11: asynchronous output enable
        rd_cpu(6'd12, d, dr);
        oe_n = 1'b1;
        #1;
        check("R11 oe high hides drive", W'(dout_drive), W'(0));
        oe_n = 1'b0;
        #1;
        check("R11 oe low restores drive", W'(dout_drive), W'(1));
        check("R11 register kept", dout, shadow[12]);

        // R12: sleep and three-cycle wake-up
        sleep = 1'b1;
        strobe_ctl_n = 1'b0; addr = 6'd50; wr_all_n = 1'b0; din = 36'hD_EAD0_0001;
        tick();
        check("R12 asleep no drive", W'(dout_drive), W'(0));
        tick();
        tick();
        sleep = 1'b0;
        tick();
        for (int c = 0; c < 3; c++) begin
            strobe_ctl_n = 1'b0; addr = 6'd50; wr_all_n = 1'b0;
            din = 36'hD_EAD0_0010 + 36'(c);
            tick();
        end
        idle_in();
        strobe_cpu_n = 1'b0; addr = 6'd50;
        tick();
        idle_in();
        check("R12 last wake edge ignored", W'(dout_drive), W'(0));
        tick();
        check("R12 first awake read drives", W'(dout_drive), W'(1));
        check("R12 contents preserved", dout, shadow[50]);

        summary();
    end

endmodule